// File: doc/BRIEF.md
# Banked Buffer Memory Self-Test Engine

This block is a built-in self-test sequencer for a packet buffer memory that is split into several equal banks, only one of which is visible at a time through a fixed-size window. A bank-select register outside the block decides which bank the window shows. The engine drives that register and a simple synchronous word port into the window. After a single start pulse it sweeps all banks four times. The first sweep fills each bank with an incrementing pattern. The second sweep reads the pattern back and checks it. The third sweep clears the memory. The fourth sweep confirms that every word reads as zero.

The pattern for a word is a seed constant plus the word's index inside its bank, taken modulo 2^16. The index starts again at zero in each bank. Before any access to a bank, the engine writes the bank number to the select register with an enable flag set. The engine stops at the first word that reads back wrong. It then reports which bank failed, the word offset inside the window, and the value it read. A clean run ends with a pass indication. In both cases a one-cycle done strobe marks the end of the run. The status stays on the ports until the next run starts.

The bank count, the window size and the seed are parameters. The memory returns read data in the cycle after the address is presented.

Top module: `banked_mem_bist`

## Requirements
- R1: After reset, busy, done, pass_ok and fail are 0, and neither mem_en nor bank_sel_we is asserted. No memory or bank-select access happens while busy is 0.
- R2: In each of the four sweeps, banks are selected in ascending order 0..NUM_BANKS-1. Each selection is a one-cycle bank_sel_we pulse. In bank_sel_data, bit BANK_W is the enable flag and is 1, and bits BANK_W-1:0 hold the bank number. The first memory access to that bank follows in the next cycle.
- R3: In sweep 1, for each bank, the engine writes words 0..WORDS-1 in ascending order on consecutive cycles. The data written is (SEED + word index) mod 2^16.
- R4: In sweep 2, the engine reads every word of every bank. It compares the data returned one cycle after the address against (SEED + word index) mod 2^16.
- R5: In sweep 3, the engine writes zero to every word of every bank.
- R6: In sweep 4, the engine reads every word of every bank and compares it against zero.
- R7: On the first mismatch, the engine stops with no further memory access or bank selection. This holds even when the failing word is the last word of a bank. done pulses and fail becomes 1. fail_bank, fail_offset and fail_rdata give the bank, the word offset and the value read.
- R8: A run with no mismatch ends with done high for exactly one cycle, pass_ok = 1 and fail = 0. It makes 4*NUM_BANKS selections, 2*NUM_BANKS*WORDS writes and 2*NUM_BANKS*WORDS reads. pass_ok and fail are never both 1.
- R9: While busy is 1 (from the start until the cycle after done), start is ignored. Once busy falls, pass_ok, fail and the failure details hold their values until the next start.
- R10: A start accepted while idle clears pass_ok and fail on the same edge that raises busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a test run when the engine is idle |
| busy | output | 1 | High from the accepted start through the done cycle |
| done | output | 1 | One-cycle strobe at the end of a run |
| pass_ok | output | 1 | Last run finished with no mismatch |
| fail | output | 1 | Last run stopped on a mismatch |
| fail_bank | output | BANK_W | Bank of the first mismatch |
| fail_offset | output | ADDR_W | Word offset of the first mismatch |
| fail_rdata | output | DATA_W | Value read at the first mismatch |
| bank_sel_we | output | 1 | Write strobe to the bank-select register |
| bank_sel_data | output | BANK_W+1 | Bit BANK_W is the enable flag; the low bits are the bank number |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when 1, read when 0 (qualified by mem_en) |
| mem_addr | output | ADDR_W | Word offset within the window |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read |

## Verification
The only internal state is the sweep, bank and word position, plus the one-cycle compare stage. If the position is wrong, the port sequence shows it within one access: an address that does not step by one, a selection out of order, or a written value that does not equal seed plus offset. A wrong compare stage shows up when the run ends. A missed mismatch gives a false pass after the full sweep count. A false mismatch gives a fail with implausible details. A missed stop shows up as extra selections or writes. For this reason the bench counts every selection and access after each stop. It also injects read-flip, stuck-high and dropped-write faults on chosen words, including the last word of a bank and the first word of the last bank.

// File: rtl/banked_mem_bist.sv
module banked_mem_bist #(
  parameter int              NUM_BANKS    = 8,
  parameter int              WINDOW_BYTES = 8192,
  parameter int              DATA_W       = 16,
  parameter logic [DATA_W-1:0] SEED       = 16'h5A00,
  localparam int             WORDS        = WINDOW_BYTES / (DATA_W / 8),
  localparam int             ADDR_W       = $clog2(WORDS),
  localparam int             BANK_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass_ok,
  output logic              fail,
  output logic [BANK_W-1:0] fail_bank,
  output logic [ADDR_W-1:0] fail_offset,
  output logic [DATA_W-1:0] fail_rdata,
  output logic              bank_sel_we,
  output logic [BANK_W:0]   bank_sel_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  typedef enum logic [2:0] {ST_IDLE, ST_SEL, ST_RUN, ST_TAIL, ST_DONE} st_t;

  st_t               st;
  logic [1:0]        sweep;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] word_q;

  logic              chk_v;
  logic              chk_zero;
  logic [BANK_W-1:0] chk_bank;
  logic [ADDR_W-1:0] chk_word;

  wire [DATA_W-1:0] chk_expect = chk_zero ? '0 : DATA_W'(SEED + DATA_W'(chk_word));
  wire              miss       = chk_v && (mem_rdata != chk_expect);
  wire              last_word  = (word_q == ADDR_W'(WORDS - 1));
  wire              last_bank  = (bank_q == BANK_W'(NUM_BANKS - 1));

  assign busy          = (st != ST_IDLE);
  assign done          = (st == ST_DONE);
  assign bank_sel_we   = (st == ST_SEL) && !miss;
  assign bank_sel_data = {1'b1, bank_q};
  assign mem_en        = (st == ST_RUN) && !miss;
  assign mem_we        = mem_en && !sweep[0];
  assign mem_addr      = word_q;
  assign mem_wdata     = (sweep == 2'd0) ? DATA_W'(SEED + DATA_W'(word_q)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      sweep       <= '0;
      bank_q      <= '0;
      word_q      <= '0;
      chk_v       <= 1'b0;
      chk_zero    <= 1'b0;
      chk_bank    <= '0;
      chk_word    <= '0;
      pass_ok     <= 1'b0;
      fail        <= 1'b0;
      fail_bank   <= '0;
      fail_offset <= '0;
      fail_rdata  <= '0;
    end else begin
      chk_v    <= mem_en && sweep[0];
      chk_zero <= (sweep == 2'd3);
      chk_bank <= bank_q;
      chk_word <= word_q;

      case (st)
        ST_IDLE: if (start) begin
          st      <= ST_SEL;
          sweep   <= '0;
          bank_q  <= '0;
          word_q  <= '0;
          pass_ok <= 1'b0;
          fail    <= 1'b0;
        end
        ST_SEL: st <= ST_RUN;
        ST_RUN: begin
          if (last_word) begin
            word_q <= '0;
            if (last_bank) begin
              bank_q <= '0;
              if (sweep == 2'd3) begin
                st <= ST_TAIL;
              end else begin
                sweep <= sweep + 2'd1;
                st    <= ST_SEL;
              end
            end else begin
              bank_q <= bank_q + 1'b1;
              st     <= ST_SEL;
            end
          end else begin
            word_q <= word_q + 1'b1;
          end
        end
        ST_TAIL: begin
          st      <= ST_DONE;
          pass_ok <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase

      if (miss) begin
        st          <= ST_DONE;
        chk_v       <= 1'b0;
        pass_ok     <= 1'b0;
        fail        <= 1'b1;
        fail_bank   <= chk_bank;
        fail_offset <= chk_word;
        fail_rdata  <= mem_rdata;
      end
    end
  end

endmodule

module banked_mem_bist_chk #(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              pass_ok,
  input logic              fail,
  input logic [BANK_W-1:0] fail_bank,
  input logic [ADDR_W-1:0] fail_offset,
  input logic              bank_sel_we,
  input logic [BANK_W:0]   bank_sel_data,
  input logic              mem_en,
  input logic [ADDR_W-1:0] mem_addr
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en || bank_sel_we) |-> busy);

  assert_sel_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel_we |-> bank_sel_data[BANK_W]);

  assert_sel_then_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel_we |=> mem_en);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  assert_stop_on_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (done && !mem_en && !bank_sel_we));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_status_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_ok && fail));

  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(pass_ok) && $stable(fail) &&
                                 $stable(fail_bank) && $stable(fail_offset)));

endmodule

bind banked_mem_bist banked_mem_bist_chk #(
  .BANK_W(BANK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pass_ok(pass_ok),
  .fail(fail), .fail_bank(fail_bank), .fail_offset(fail_offset),
  .bank_sel_we(bank_sel_we), .bank_sel_data(bank_sel_data),
  .mem_en(mem_en), .mem_addr(mem_addr)
);

// File: tb/banked_mem_bist_bench.sv
module banked_mem_bist_bench;
  localparam int NB   = 4;
  localparam int WB   = 64;
  localparam int W    = WB / 2;
  localparam int AW   = $clog2(W);
  localparam int BW   = $clog2(NB);
  localparam logic [15:0] SEED = 16'hFFF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, pass_ok, fail;
  logic [BW-1:0] fail_bank;
  logic [AW-1:0] fail_offset;
  logic [15:0]   fail_rdata;
  logic          bank_sel_we;
  logic [BW:0]   bank_sel_data;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  banked_mem_bist #(.NUM_BANKS(NB), .WINDOW_BYTES(WB), .DATA_W(16), .SEED(SEED)) u_banked_mem_bist (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass_ok(pass_ok), .fail(fail), .fail_bank(fail_bank),
    .fail_offset(fail_offset), .fail_rdata(fail_rdata),
    .bank_sel_we(bank_sel_we), .bank_sel_data(bank_sel_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model with fault injection: 0 none, 1 xor on read, 2 or on read, 3 drop write
  logic [15:0] mem [0:NB*W-1];
  logic [BW-1:0] cur_bank = '0;
  int f_mode = 0, f_bank = 0, f_word = 0;
  logic [15:0] f_mask = '0;
  int run_sel = 0, run_wr = 0, run_rd = 0;
  int sel_err = 0, pat_err = 0, idle_err = 0;

  always @(posedge clk) begin
    if (start && !busy) begin
      run_sel <= 0; run_wr <= 0; run_rd <= 0;
    end
    if ((bank_sel_we || mem_en) && !busy) idle_err <= idle_err + 1;
    if (bank_sel_we) begin
      if (bank_sel_data != {1'b1, BW'(run_sel % NB)}) sel_err <= sel_err + 1;
      cur_bank <= bank_sel_data[BW-1:0];
      run_sel  <= run_sel + 1;
    end
    if (mem_en && mem_we) begin
      if (int'(mem_addr) != run_wr % W || int'(cur_bank) != (run_wr / W) % NB ||
          mem_wdata != ((run_wr < NB*W) ? 16'(SEED + 16'(run_wr % W)) : 16'h0))
        pat_err <= pat_err + 1;
      if (!(f_mode == 3 && int'(cur_bank) == f_bank && int'(mem_addr) == f_word))
        mem[int'(cur_bank)*W + int'(mem_addr)] <= mem_wdata;
      run_wr <= run_wr + 1;
    end
    if (mem_en && !mem_we) begin
      if (f_mode == 1 && int'(cur_bank) == f_bank && int'(mem_addr) == f_word)
        mem_rdata <= mem[int'(cur_bank)*W + int'(mem_addr)] ^ f_mask;
      else if (f_mode == 2 && int'(cur_bank) == f_bank && int'(mem_addr) == f_word)
        mem_rdata <= mem[int'(cur_bank)*W + int'(mem_addr)] | f_mask;
      else
        mem_rdata <= mem[int'(cur_bank)*W + int'(mem_addr)];
      run_rd <= run_rd + 1;
    end
  end

  int n_cmp = 0, n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R8", "done seen", done, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check({busy, done, pass_ok, fail, mem_en, bank_sel_we} == 6'b0, "R1",
          "reset outputs", {busy, done, pass_ok, fail, mem_en, bank_sel_we}, 0);
  endtask

  task automatic t_clean();
    f_mode = 0;
    pulse_start();
    wait_done();
    check(pass_ok == 1'b1 && fail == 1'b0, "R8", "clean status", {pass_ok, fail}, 2'b10);
    check(run_sel == 4*NB, "R2", "selection count", run_sel, 4*NB);
    check(run_wr == 2*NB*W, "R5", "write count", run_wr, 2*NB*W);
    check(run_rd == 2*NB*W, "R4", "read count", run_rd, 2*NB*W);
    check(sel_err == 0, "R2", "selection order/enable errors", sel_err, 0);
    check(pat_err == 0, "R3", "write pattern errors", pat_err, 0);
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", done, 0);
    begin
      int nz = 0;
      for (int i = 0; i < NB*W; i++) if (mem[i] != 16'h0) nz++;
      check(nz == 0, "R5", "nonzero words after clear", nz, 0);
    end
    repeat (10) @(negedge clk);
    check(pass_ok == 1'b1 && busy == 1'b0, "R9", "status held", {pass_ok, busy}, 2'b10);
  endtask

  task automatic t_fault(input int mode, input int b, input int w, input logic [15:0] m,
                         input logic [15:0] exp_rd, input int exp_sel, input int exp_wr,
                         input string req);
    f_mode = mode; f_bank = b; f_word = w; f_mask = m;
    pulse_start();
    check(fail == 1'b0 && pass_ok == 1'b0 && busy == 1'b1, "R10", "status cleared on start",
          {fail, pass_ok, busy}, 3'b001);
    wait_done();
    check(fail == 1'b1 && pass_ok == 1'b0, req, "fail flag", {fail, pass_ok}, 2'b10);
    check(int'(fail_bank) == b, req, "fail bank", fail_bank, b);
    check(int'(fail_offset) == w, req, "fail offset", fail_offset, w);
    check(fail_rdata == exp_rd, req, "fail read value", fail_rdata, exp_rd);
    check(run_sel == exp_sel, "R7", "selections at stop", run_sel, exp_sel);
    check(run_wr == exp_wr, "R7", "writes at stop", run_wr, exp_wr);
    repeat (8) @(negedge clk);
    check(run_sel == exp_sel && run_wr == exp_wr, "R7", "no access after stop",
          run_sel + run_wr, exp_sel + exp_wr);
    check(fail == 1'b1 && int'(fail_offset) == w, "R9", "fail details held", fail_offset, w);
    f_mode = 0;
  endtask

  task automatic t_start_ignored();
    f_mode = 0;
    pulse_start();
    repeat (100) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    check(run_sel == 4*NB && run_wr == 2*NB*W, "R9", "start while busy ignored",
          run_sel, 4*NB);
    check(pass_ok == 1'b1, "R9", "pass after ignored start", pass_ok, 1);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB*W; i++) mem[i] = 16'hDEAD;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_clean();
    // R4: flipped bit on the last word of bank 2, caught in the pattern sweep
    t_fault(1, 2, W-1, 16'h0100, 16'(SEED + 16'(W-1)) ^ 16'h0100, NB + 3, NB*W, "R4");
    // R6: bit stuck high, invisible to the pattern, caught in the zero sweep
    t_fault(2, 1, 5, 16'h0001, 16'h0001, 3*NB + 2, 2*NB*W, "R6");
    // R4: lost write at word 0 of the last bank, reads the cleared value
    t_fault(3, NB-1, 0, 16'h0000, 16'h0000, NB + NB, NB*W, "R4");
    t_start_ignored();
    t_clean();
    check(idle_err == 0, "R1", "accesses while idle", idle_err, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule